// File: doc/BRIEF.md
# Dual-Register Timer Capture Unit

This block sits next to a free-running 16-bit up-counter and takes snapshots of the counter value into two capture registers. The edges that load each register come from two external pins, A and B, and from an internal timer flip-flop. A 2-bit capture mode selects which of these edges are used. A software strobe in the control register can force a snapshot into the first register in any mode. The block also sends a one-cycle interrupt request for pin A. Host software reads each 16-bit snapshot over an 8-bit bus as two bytes.

The mode register is the block's state machine. It has four named states. `MODE_OFF` performs no hardware capture and is the reset state. In `MODE_PINS`, a rising edge on A loads register 1 and a rising edge on B loads register 2. In `MODE_SPLIT`, register 1 loads on the rising edge of A and register 2 on the falling edge of A. In `MODE_TFF`, register 1 loads on the rising edge of the timer flip-flop and register 2 on its falling edge. Every transition is a control-register write. A write with mode field value m moves from any state to the state encoded by m, including the current state. The only transition that needs no write is reset, which returns the machine to `MODE_OFF`. The new state takes effect at the clock edge that accepts the write. Edges seen in that same cycle are still decoded under the old state.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset, both capture registers read 0, the control register reads 8'h04 and `irq_a` is low.
- R2: In mode 2'b00 (`MODE_OFF`), no edge on A, B or the timer flip-flop changes either capture register.
- R3: In mode 2'b01 (`MODE_PINS`), a rising edge of A loads register 1 and a rising edge of B loads register 2. Falling edges and timer flip-flop edges load nothing.
- R4: In mode 2'b10 (`MODE_SPLIT`), a rising edge of A loads register 1 and a falling edge of A loads register 2. Edges on B and on the timer flip-flop load nothing.
- R5: In mode 2'b11 (`MODE_TFF`), a rising edge of `tff_in` loads register 1 and a falling edge loads register 2. Edges on A and B load nothing.
- R6: `irq_a` is a pulse exactly one cycle long. In `MODE_SPLIT` it follows a falling edge of A. In the other three modes it follows a rising edge of A. It never follows B or the timer flip-flop.
- R7: A write to address 4 puts `wdata[1:0]` into the mode field. If `wdata[2]` is 0, the same clock edge loads `cnt_val` into register 1, whatever the mode. If `wdata[2]` is 1, no load happens.
- R8: The read map is as follows. Address 0 returns the register 1 low byte. Address 2 returns the register 2 low byte. Address 4 returns {5'b0, 1'b1, mode}. Addresses 5 to 7 return 0.
- R9: A read of a low byte (address 0 or 2) copies that register's high byte into its own holding byte. Address 1 or 3 then returns the holding byte, so a capture between the two reads cannot tear the 16-bit result.
- R10: A level change on A or B that is set up before clock edge 1 loads the `cnt_val` sampled at edge 3, and `irq_a` is high only after edge 3. A change on `tff_in` loads the value sampled at edge 1.
- R11: If a hardware load and a software load of register 1 fall in the same cycle, register 1 takes the `cnt_val` of that cycle once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_val | input | 16 | Current value of the free-running up-counter |
| ext_a | input | 1 | Asynchronous external capture pin A |
| ext_b | input | 1 | Asynchronous external capture pin B |
| tff_in | input | 1 | Synchronous timer flip-flop output |
| wr_en | input | 1 | Write strobe for the control register |
| rd_en | input | 1 | Read strobe, updates the holding bytes |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_a | output | 1 | One-cycle interrupt request for pin A |

## Verification
Assertions check some rules on every cycle. An edge strobe never lasts two cycles, and the interrupt is always a single pulse. In `MODE_OFF`, neither register moves unless software asks for a load. In `MODE_SPLIT`, register 2 moves only after a falling edge of A. A software strobe always leaves register 1 equal to the counter value of the previous cycle, and a low-byte read always leaves the matching high byte in its holding byte. The bench scenarios cover what needs a particular order of events. These are the exact counter value taken relative to the pin change, the per-mode mapping of every edge source, the tear-free read when a capture falls between the two byte reads, and a software strobe that lands in the same cycle as a timer flip-flop edge.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_PINS  = 2'b01,
        MODE_SPLIT = 2'b10,
        MODE_TFF   = 2'b11
    } cap_mode_e;

    localparam int ADDR_W    = 3;
    localparam int SWCAP_BIT = 2;

    localparam logic [ADDR_W-1:0] ADR_C1_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_C1_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_C2_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_C2_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd4;

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic lvl;
    logic lvl_d;

    generate
        if (STAGES == 0) begin : g_direct
            assign lvl = din;
        end else begin : g_sync
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign lvl = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R10
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R10

endmodule

// File: rtl/cap_source_sel.sv
module cap_source_sel
    import cap_pkg::*;
(
    input  cap_mode_e  mode,
    input  logic [2:0] rise,
    input  logic [2:0] fall,
    output logic       ld1,
    output logic       ld2,
    output logic       irq_evt
);

    logic unused_fall_b;
    assign unused_fall_b = fall[1];

    always_comb begin
        ld1     = 1'b0;
        ld2     = 1'b0;
        irq_evt = rise[0];
        unique case (mode)
            MODE_OFF: begin
                ld1 = 1'b0;
                ld2 = 1'b0;
            end
            MODE_PINS: begin
                ld1 = rise[0];
                ld2 = rise[1];
            end
            MODE_SPLIT: begin
                ld1     = rise[0];
                ld2     = fall[0];
                irq_evt = fall[0];
            end
            MODE_TFF: begin
                ld1 = rise[2];
                ld2 = fall[2];
            end
        endcase
    end

endmodule

// File: rtl/cap_bus_port.sv
module cap_bus_port
    import cap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] cap1,
    input  logic [2*DATA_W-1:0] cap2,
    output cap_mode_e           mode,
    output logic                sw_cap,
    output logic [DATA_W-1:0]   rdata
);

    logic              ctrl_wr;
    cap_mode_e         mode_nxt;
    logic [DATA_W-1:0] hold1;
    logic [DATA_W-1:0] hold2;
    logic              unused_wbits;

    assign unused_wbits = ^wdata[DATA_W-1:SWCAP_BIT+1];
    assign ctrl_wr      = wr_en && (addr == ADR_CTRL);

    // next-state: any write moves to the encoded mode
    always_comb begin
        mode_nxt = mode;
        if (ctrl_wr) mode_nxt = cap_mode_e'(wdata[1:0]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_OFF;
        else        mode <= mode_nxt;
    end

    // outputs: software strobe is active low
    always_comb begin
        sw_cap = ctrl_wr && !wdata[SWCAP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold1 <= '0;
            hold2 <= '0;
        end else if (rd_en) begin
            if (addr == ADR_C1_LO) hold1 <= cap1[2*DATA_W-1:DATA_W];
            if (addr == ADR_C2_LO) hold2 <= cap2[2*DATA_W-1:DATA_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_C1_LO: rdata = cap1[DATA_W-1:0];
            ADR_C1_HI: rdata = hold1;
            ADR_C2_LO: rdata = cap2[DATA_W-1:0];
            ADR_C2_HI: rdata = hold2;
            ADR_CTRL: begin
                rdata[1:0]       = mode;
                rdata[SWCAP_BIT] = 1'b1;
            end
            default:   rdata = '0;
        endcase
    end

    AST_HOLD1_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_C1_LO) |=> hold1 == $past(cap1[2*DATA_W-1:DATA_W])); // R9
    AST_HOLD2_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_C2_LO) |=> hold2 == $past(cap2[2*DATA_W-1:DATA_W])); // R9

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
    import cap_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] cnt_val,
    input  logic                ext_a,
    input  logic                ext_b,
    input  logic                tff_in,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq_a
);

    localparam int CNT_W = 2 * DATA_W;
    localparam int N_SRC = 3;
    localparam int TFF_IDX = 2;

    logic [N_SRC-1:0] pins;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] fall;
    logic             ld1;
    logic             ld2;
    logic             irq_evt;
    logic             sw_cap;
    cap_mode_e        mode;
    logic [CNT_W-1:0] cap1;
    logic [CNT_W-1:0] cap2;

    assign pins = {tff_in, ext_b, ext_a};

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_edge
            cap_sync_edge #(
                .STAGES((i == TFF_IDX) ? 0 : SYNC_STAGES)
            ) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pins[i]),
                .rise (rise[i]),
                .fall (fall[i])
            );
        end
    endgenerate

    cap_source_sel u_sel (
        .mode   (mode),
        .rise   (rise),
        .fall   (fall),
        .ld1    (ld1),
        .ld2    (ld2),
        .irq_evt(irq_evt)
    );

    cap_bus_port #(.DATA_W(DATA_W)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .cap1  (cap1),
        .cap2  (cap2),
        .mode  (mode),
        .sw_cap(sw_cap),
        .rdata (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap1  <= '0;
            cap2  <= '0;
            irq_a <= 1'b0;
        end else begin
            if (ld1 || sw_cap) cap1 <= cnt_val;
            if (ld2)           cap2 <= cnt_val;
            irq_a <= irq_evt;
        end
    end

    AST_OFF_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !sw_cap) |=> ($stable(cap1) && $stable(cap2))); // R2
    AST_SPLIT_CAP2_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SPLIT && !fall[0]) |=> $stable(cap2)); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |=> !irq_a); // R6
    AST_SW_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cap |=> cap1 == $past(cnt_val)); // R7

endmodule

// File: tb/tb_tmr_capture_unit.sv
module tb_tmr_capture_unit;
    import cap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'd0;
    logic [15:0] step = 16'd1;
    logic        ext_a = 1'b0;
    logic        ext_b = 1'b0;
    logic        tff = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        irq;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] e1 = 16'd0;
    logic [15:0] e2 = 16'd0;
    logic [1:0]  cur_mode = 2'd0;
    logic [2:0]  lvl = 3'd0;

    always #10 clk = ~clk;
    always @(posedge clk) cnt <= cnt + step;

    tmr_capture_unit dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_val(cnt),
        .ext_a  (ext_a),
        .ext_b  (ext_b),
        .tff_in (tff),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .irq_a  (irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] loads(logic [1:0] m, int src, logic r);
        logic [1:0] ld = 2'b00;
        case (m)
            2'd1: begin
                if (src == 0 && r) ld = 2'b01;
                if (src == 1 && r) ld = 2'b10;
            end
            2'd2: if (src == 0) ld = r ? 2'b01 : 2'b10;
            2'd3: if (src == 2) ld = r ? 2'b01 : 2'b10;
            default: ld = 2'b00;
        endcase
        return ld;
    endfunction

    function automatic logic irq_exp(logic [1:0] m, int src, logic r);
        if (src != 0) return 1'b0;
        return (m == 2'd2) ? !r : r;
    endfunction

    function automatic string mtag(logic [1:0] m);
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(logic [2:0] base, output logic [15:0] v);
        logic [7:0] lo;
        logic [7:0] hi;
        rd(base, lo);
        rd(3'(base + 3'd1), hi);
        v = {hi, lo};
    endtask

    task automatic wr_ctrl(logic [1:0] m, logic sw);
        logic [15:0] c;
        @(negedge clk);
        addr = ADR_CTRL;
        wdata = {5'b0, ~sw, m};
        wr_en = 1'b1;
        c = cnt;
        @(negedge clk);
        wr_en = 1'b0;
        cur_mode = m;
        if (sw) e1 = c;
    endtask

    task automatic check_caps(string tag);
        logic [15:0] v;
        rd16(ADR_C1_LO, v);
        chk({tag, " cap1"}, 32'(v), 32'(e1));
        rd16(ADR_C2_LO, v);
        chk({tag, " cap2"}, 32'(v), 32'(e2));
    endtask

    task automatic evt(int src);
        logic [15:0] c;
        logic        r;
        logic [1:0]  ld;
        string       tag;
        tag = mtag(cur_mode);
        @(negedge clk);
        r = ~lvl[src];
        lvl[src] = r;
        if (src == 0) ext_a = r;
        else if (src == 1) ext_b = r;
        else tff = r;
        if (src == 2) begin
            c = cnt;
            @(negedge clk);
            chk("R6 no irq from tff", 32'(irq), 32'd0);
        end else begin
            @(negedge clk);
            @(negedge clk);
            chk("R10 irq not before edge 3", 32'(irq), 32'd0);
            c = cnt;
            @(negedge clk);
            chk("R6 irq after edge", 32'(irq), 32'(irq_exp(cur_mode, src, r)));
            @(negedge clk);
            chk("R6 irq single cycle", 32'(irq), 32'd0);
        end
        ld = loads(cur_mode, src, r);
        if (ld[0]) e1 = c;
        if (ld[1]) e2 = c;
        check_caps(tag);
    endtask

    task automatic all_edges();
        for (int k = 0; k < 6; k++) evt(k / 2);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired (R1 run did not end)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [7:0]  lo;
        logic [7:0]  hi_old;
        logic [15:0] c;
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        check_caps("R1");
        rd(ADR_CTRL, d);
        chk("R1 ctrl reset value", 32'(d), 32'h04);
        rd(3'd6, d);
        chk("R8 unmapped read", 32'(d), 32'h00);

        // R2: everything ignored while off
        all_edges();
        // R3
        wr_ctrl(2'd1, 1'b0);
        rd(ADR_CTRL, d);
        chk("R8 ctrl readback pins", 32'(d), 32'h05);
        all_edges();
        // R4
        wr_ctrl(2'd2, 1'b0);
        all_edges();
        // R5
        wr_ctrl(2'd3, 1'b0);
        all_edges();

        // R7: software strobe in split mode, then no-strobe write
        wr_ctrl(2'd2, 1'b1);
        check_caps("R7 sw capture");
        wr_ctrl(2'd0, 1'b0);
        check_caps("R7 bit high no load");
        rd(ADR_CTRL, d);
        chk("R7 mode field written", 32'(d), 32'h04);

        // R9: capture between low and high byte reads
        step = 16'h0101;
        wr_ctrl(2'd1, 1'b1);
        rd(ADR_C1_LO, lo);
        hi_old = e1[15:8];
        chk("R9 low byte", 32'(lo), 32'(e1[7:0]));
        wr_ctrl(2'd1, 1'b1);
        rd(ADR_C1_HI, d);
        chk("R9 held high byte", 32'(d), 32'(hi_old));
        check_caps("R9 fresh pair");

        // R11: timer edge and software strobe in the same cycle
        wr_ctrl(2'd3, 1'b0);
        @(negedge clk);
        tff = ~lvl[2];
        lvl[2] = tff;
        addr = ADR_CTRL;
        wdata = 8'h03;
        wr_en = 1'b1;
        c = cnt;
        @(negedge clk);
        wr_en = 1'b0;
        if (tff) e1 = c; else e2 = c;
        if (!tff) e1 = c;
        check_caps("R11 coincident");

        // randomised mix
        for (int i = 0; i < 120; i++) begin
            if (i % 10 == 0) wr_ctrl(2'($urandom % 4), 1'($urandom % 2));
            step = 16'($urandom);
            evt(int'($urandom % 3));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule